// File: doc/BRIEF.md
# Video Memory Rectangle Transfer Engine

This block copies a rectangle of 16-bit pixels between a 32-bit data port and a frame memory of 1024 columns by 512 rows. A start pulse loads a position word and a size word and chooses the direction. The engine then walks the rectangle row by row and column by column. Each data word carries two pixels. The word's low half holds the pixel at the lower X address.

The frame memory is reached through two synchronous pixel lanes that are used in the same cycle. Lane 0 takes the first pixel of a word and lane 1 takes the second. So every word that moves costs one clock, even when its two pixels sit on different rows. The engine does nothing in a cycle with no data, and it continues from the same pixel when data comes back. It can stop in the middle of a row. A read transfer raises an image-ready flag until its last pixel has been fetched. A write transfer pulses a completion strobe that carries the original rectangle, so a cache above the block can invalidate that area.

Top module: `vram_rect_xfer`

## Requirements
- R1: The start column comes from position bits 9:0 and the start row from position bits 24:16. All other position bits are ignored.
- R2: The width is taken from size bits 9:0 and the height from size bits 24:16. A field value of 0 means the maximum: 1024 columns or 512 rows. All other size bits are ignored.
- R3: A pixel at column x and row y uses memory address y*1024 + x, so the row sits in address bits 18:10 and the column in bits 9:0. Data bits 15:0 hold the earlier pixel, on lane 0. Data bits 31:16 hold the next pixel, on lane 1. The write-enable bit is 1 for a write transfer.
- R4: Pixels go in row order, left to right inside a row. The column wraps modulo 1024 inside a row. After the last column of a row the engine moves to the next row, and the row wraps modulo 512. Lane 1 is unused when the word starts on the final pixel.
- R5: In a cycle with no write word, or no read request, the engine makes no memory access. The next word continues from the exact pixel where the transfer stopped, including the middle of a row.
- R6: img_ready_o rises the cycle after a read start. It falls the cycle after the word that holds the last pixel, or when a write start replaces the read.
- R7: For a read request, rd_valid_o is high one cycle later. rd_data_o then holds the fetched pixels in the order given in R3, and an unused upper half reads as zero.
- R8: One cycle after the last pixel of a write transfer, done_o pulses for one cycle. The done_x/y/w/h outputs then give the rectangle as decoded at start.
- R9: busy_o is high from the cycle after a start until the last pixel has been handled. A start while busy drops the old transfer and begins the new one. A data word in the same cycle as a start is ignored.
- R10: During reset and just after it, busy_o, img_ready_o, done_o, rd_valid_o and both lane enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Load a new transfer |
| start_rd_i | input | 1 | 1 for read (memory to port), 0 for write |
| pos_i | input | 32 | Position word |
| size_i | input | 32 | Size word |
| wr_valid_i | input | 1 | A write data word is present |
| wr_data_i | input | 32 | Write data, two pixels |
| rd_req_i | input | 1 | Request one read word |
| rd_valid_o | output | 1 | Read word is valid |
| rd_data_o | output | 32 | Read data, two pixels |
| busy_o | output | 1 | Transfer pending |
| img_ready_o | output | 1 | Read transfer pending |
| done_o | output | 1 | Write transfer completed (one-cycle pulse) |
| done_x_o | output | 10 | Start column of the completed rectangle |
| done_y_o | output | 9 | Start row of the completed rectangle |
| done_w_o | output | 11 | Width of the completed rectangle |
| done_h_o | output | 10 | Height of the completed rectangle |
| mem_en_o | output | 2 | Per-lane memory enable |
| mem_we_o | output | 1 | Write enable, shared by both lanes |
| mem_addr_o | output | 38 | Lane addresses, lane k at bits 19k+18:19k |
| mem_wdata_o | output | 32 | Lane write data, lane k at bits 16k+15:16k |
| mem_rdata_i | input | 32 | Lane read data, one cycle after enable |

## Verification
The bench uses the default parameters: 10 column bits and 9 row bits, which give the full 1024 by 512 grid. With that grid the real wrap points can be tested. A rectangle starts at column 1022 and row 510 and crosses both edges. A zero width field gives a 1024-pixel row, and a zero height field gives 512 rows. These cases run in a few hundred cycles, because each word moves two pixels.

// File: rtl/vrx_pkg.sv
package vrx_pkg;
  localparam int PIX_W = 16;
  localparam int LANES = 2;

  typedef enum logic {
    DIR_WRITE = 1'b0,
    DIR_READ  = 1'b1
  } dir_e;
endpackage

// File: rtl/vrx_rect_decode.sv
module vrx_rect_decode #(
  parameter int CB = 10,
  parameter int RB = 9
) (
  input  logic [31:0]   pos_i,
  input  logic [31:0]   size_i,
  output logic [CB-1:0] x0_o,
  output logic [RB-1:0] y0_o,
  output logic [CB:0]   w_o,
  output logic [RB:0]   h_o
);
  logic [CB-1:0] wf;
  logic [RB-1:0] hf;
  logic          unused_bits;

  assign x0_o = pos_i[CB-1:0];
  assign y0_o = pos_i[16 +: RB];
  assign wf   = size_i[CB-1:0];
  assign hf   = size_i[16 +: RB];
  // zero field selects the full span
  assign w_o  = (wf == '0) ? {1'b1, {CB{1'b0}}} : {1'b0, wf};
  assign h_o  = (hf == '0) ? {1'b1, {RB{1'b0}}} : {1'b0, hf};
  assign unused_bits = ^{pos_i[31:16+RB], pos_i[15:CB], size_i[31:16+RB], size_i[15:CB]};
endmodule

// File: rtl/vrx_pixel_step.sv
module vrx_pixel_step #(
  parameter int CB = 10,
  parameter int RB = 9
) (
  input  logic [CB-1:0]    x0_i,
  input  logic [CB:0]      w_i,
  input  logic [CB-1:0]    off_i,
  input  logic [RB-1:0]    row_i,
  input  logic [RB:0]      left_i,
  output logic             act_o,
  output logic [CB+RB-1:0] addr_o,
  output logic [CB-1:0]    off_o,
  output logic [RB-1:0]    row_o,
  output logic [RB:0]      left_o
);
  logic [CB:0]   inc;
  logic [CB-1:0] col;

  always_comb begin
    inc    = {1'b0, off_i} + (CB+1)'(1);
    col    = x0_i + off_i;
    act_o  = (left_i != '0);
    addr_o = {row_i, col};
    off_o  = off_i;
    row_o  = row_i;
    left_o = left_i;
    if (act_o) begin
      if (inc == w_i) begin
        off_o  = '0;
        row_o  = row_i + RB'(1);
        left_o = left_i - (RB+1)'(1);
      end else begin
        off_o  = inc[CB-1:0];
      end
    end
  end
endmodule

// File: rtl/vram_rect_xfer.sv
module vram_rect_xfer
  import vrx_pkg::*;
#(
  parameter int CB = 10,
  parameter int RB = 9,
  localparam int AW = CB + RB,
  localparam int DW = LANES * PIX_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic                start_rd_i,
  input  logic [31:0]         pos_i,
  input  logic [31:0]         size_i,
  input  logic                wr_valid_i,
  input  logic [DW-1:0]       wr_data_i,
  input  logic                rd_req_i,
  output logic                rd_valid_o,
  output logic [DW-1:0]       rd_data_o,
  output logic                busy_o,
  output logic                img_ready_o,
  output logic                done_o,
  output logic [CB-1:0]       done_x_o,
  output logic [RB-1:0]       done_y_o,
  output logic [CB:0]         done_w_o,
  output logic [RB:0]         done_h_o,
  output logic [LANES-1:0]    mem_en_o,
  output logic                mem_we_o,
  output logic [LANES*AW-1:0] mem_addr_o,
  output logic [DW-1:0]       mem_wdata_o,
  input  logic [DW-1:0]       mem_rdata_i
);
  // reset: asynchronous assertion, synchronous release
  logic [1:0] rsync_q;
  logic       rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_q_n = rsync_q[1];

  // decoded start fields
  logic [CB-1:0] dx0;
  logic [RB-1:0] dy0;
  logic [CB:0]   dw;
  logic [RB:0]   dh;
  vrx_rect_decode #(.CB(CB), .RB(RB)) u_dec (
    .pos_i(pos_i), .size_i(size_i), .x0_o(dx0), .y0_o(dy0), .w_o(dw), .h_o(dh)
  );

  // state
  logic          busy_q, busy_d, img_q, img_d, done_q, done_d;
  logic          rvld_q, rvld_d, rhi_q, rhi_d;
  dir_e          dir_q, dir_d;
  logic [CB-1:0] x0_q, x0_d, off_q, off_d;
  logic [RB-1:0] y0_q, y0_d, row_q, row_d;
  logic [CB:0]   w_q, w_d;
  logic [RB:0]   h_q, h_d, left_q, left_d;

  logic          fire;
  logic [CB-1:0] off_c  [LANES+1];
  logic [RB-1:0] row_c  [LANES+1];
  logic [RB:0]   left_c [LANES+1];
  logic [LANES-1:0] act_c;

  assign fire = busy_q && !start_i && ((dir_q == DIR_READ) ? rd_req_i : wr_valid_i);

  assign off_c[0]  = off_q;
  assign row_c[0]  = row_q;
  assign left_c[0] = left_q;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    vrx_pixel_step #(.CB(CB), .RB(RB)) u_step (
      .x0_i(x0_q), .w_i(w_q),
      .off_i(off_c[k]), .row_i(row_c[k]), .left_i(left_c[k]),
      .act_o(act_c[k]), .addr_o(mem_addr_o[k*AW +: AW]),
      .off_o(off_c[k+1]), .row_o(row_c[k+1]), .left_o(left_c[k+1])
    );
    assign mem_en_o[k] = fire && act_c[k];
  end

  assign mem_we_o    = fire && (dir_q == DIR_WRITE);
  assign mem_wdata_o = wr_data_i;

  // next state
  always_comb begin
    busy_d = busy_q; img_d = img_q; dir_d = dir_q;
    x0_d = x0_q; y0_d = y0_q; w_d = w_q; h_d = h_q;
    off_d = off_q; row_d = row_q; left_d = left_q;
    done_d = 1'b0;
    rvld_d = fire && (dir_q == DIR_READ);
    rhi_d  = mem_en_o[1] && (dir_q == DIR_READ);
    if (start_i) begin
      busy_d = 1'b1;
      dir_d  = start_rd_i ? DIR_READ : DIR_WRITE;
      img_d  = start_rd_i;
      x0_d = dx0; y0_d = dy0; w_d = dw; h_d = dh;
      off_d = '0; row_d = dy0; left_d = dh;
    end else if (fire) begin
      off_d  = off_c[LANES];
      row_d  = row_c[LANES];
      left_d = left_c[LANES];
      if (left_c[LANES] == '0) begin
        busy_d = 1'b0;
        img_d  = 1'b0;
        done_d = (dir_q == DIR_WRITE);
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      busy_q <= 1'b0; img_q <= 1'b0; done_q <= 1'b0; dir_q <= DIR_WRITE;
      rvld_q <= 1'b0; rhi_q <= 1'b0;
      x0_q <= '0; y0_q <= '0; w_q <= '0; h_q <= '0;
      off_q <= '0; row_q <= '0; left_q <= '0;
    end else begin
      busy_q <= busy_d; img_q <= img_d; done_q <= done_d; dir_q <= dir_d;
      rvld_q <= rvld_d; rhi_q <= rhi_d;
      if (start_i) begin
        x0_q <= x0_d; y0_q <= y0_d; w_q <= w_d; h_q <= h_d;
      end
      if (start_i || fire) begin
        off_q <= off_d; row_q <= row_d; left_q <= left_d;
      end
    end
  end

  assign busy_o      = busy_q;
  assign img_ready_o = img_q;
  assign done_o      = done_q;
  assign done_x_o    = x0_q;
  assign done_y_o    = y0_q;
  assign done_w_o    = w_q;
  assign done_h_o    = h_q;
  assign rd_valid_o  = rvld_q;
  assign rd_data_o   = rvld_q ? {(rhi_q ? mem_rdata_i[DW-1:PIX_W] : {PIX_W{1'b0}}),
                                 mem_rdata_i[PIX_W-1:0]} : '0;

  // R9
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    start_i |=> busy_o);
  // R8
  done_src_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    done_o |-> (!busy_o && $past(mem_we_o)));
  // R7
  rd_src_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    rd_valid_o |-> $past(mem_en_o[0] && !mem_we_o));
  // R3
  lane_order_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    mem_en_o[1] |-> mem_en_o[0]);
  // R6
  img_fall_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    $fell(img_ready_o) |-> $past(rd_req_i || start_i));
  // R4
  cursor_in_row_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    busy_q |-> ({1'b0, off_q} < w_q));
endmodule

// File: tb/sim_vram_rect_xfer.sv
module sim_vram_rect_xfer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i, start_rd_i, wr_valid_i, rd_req_i;
  logic [31:0] pos_i, size_i, wr_data_i;
  logic        rd_valid_o, busy_o, img_ready_o, done_o, mem_we_o;
  logic [31:0] rd_data_o, mem_wdata_o, mem_rdata_i;
  logic [9:0]  done_x_o;
  logic [8:0]  done_y_o;
  logic [10:0] done_w_o;
  logic [9:0]  done_h_o;
  logic [1:0]  mem_en_o;
  logic [37:0] mem_addr_o;

  always #4 clk = ~clk;

  vram_rect_xfer u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_rd_i(start_rd_i),
    .pos_i(pos_i), .size_i(size_i), .wr_valid_i(wr_valid_i), .wr_data_i(wr_data_i),
    .rd_req_i(rd_req_i), .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o),
    .busy_o(busy_o), .img_ready_o(img_ready_o), .done_o(done_o),
    .done_x_o(done_x_o), .done_y_o(done_y_o), .done_w_o(done_w_o), .done_h_o(done_h_o),
    .mem_en_o(mem_en_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i)
  );

  function automatic logic [15:0] pat(int a);
    return 16'((a * 7 + 3) & 16'hFFFF);
  endfunction

  // frame memory seen by the design
  logic [15:0] bmem [int];
  logic [15:0] rq0, rq1;
  assign mem_rdata_i = {rq1, rq0};
  always @(posedge clk) begin
    if (mem_en_o[0]) begin
      if (mem_we_o) bmem[int'(mem_addr_o[18:0])] = mem_wdata_o[15:0];
      else rq0 <= bmem.exists(int'(mem_addr_o[18:0])) ? bmem[int'(mem_addr_o[18:0])] : pat(int'(mem_addr_o[18:0]));
    end
    if (mem_en_o[1]) begin
      if (mem_we_o) bmem[int'(mem_addr_o[37:19])] = mem_wdata_o[31:16];
      else rq1 <= bmem.exists(int'(mem_addr_o[37:19])) ? bmem[int'(mem_addr_o[37:19])] : pat(int'(mem_addr_o[37:19]));
    end
  end

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // reference model
  int   q[$];
  logic [15:0] refm [int];
  bit   m_busy = 0, m_img = 0, m_done = 0, m_dir = 0, m_rvld = 0;
  logic [31:0] m_rdata = '0;
  int   mx = 0, my = 0, mw = 0, mh = 0;
  int   wcnt = 1;

  function automatic logic [15:0] refget(int a);
    return refm.exists(a) ? refm[a] : pat(a);
  endfunction

  task automatic cyc(input bit st, input bit sdir, input logic [31:0] pos,
                     input logic [31:0] size, input bit wv, input bit rr,
                     input string tag);
    bit fire, e1;
    int a0, a1;
    logic [31:0] wd;
    wd = {16'(wcnt * 3 + 1), 16'(wcnt * 5 + 2)};
    wcnt++;
    @(negedge clk);
    start_i = st; start_rd_i = sdir; pos_i = pos; size_i = size;
    wr_valid_i = wv; wr_data_i = wd; rd_req_i = rr;
    #2;
    chk(busy_o == m_busy, "R9", "busy", busy_o, m_busy);
    chk(img_ready_o == m_img, "R6", "img_ready", img_ready_o, m_img);
    chk(done_o == m_done, "R8", "done", done_o, m_done);
    if (m_done) begin
      chk(done_x_o == 10'(mx) && done_y_o == 9'(my), "R8", "done xy",
          {done_y_o, done_x_o}, {9'(my), 10'(mx)});
      chk(done_w_o == 11'(mw) && done_h_o == 10'(mh), "R8", "done wh",
          {done_h_o, done_w_o}, {10'(mh), 11'(mw)});
    end
    chk(rd_valid_o == m_rvld, "R7", "rd_valid", rd_valid_o, m_rvld);
    if (m_rvld) chk(rd_data_o == m_rdata, "R7", "rd_data", rd_data_o, m_rdata);
    fire = m_busy && !st && (m_dir ? rr : wv);
    e1 = 0; a0 = 0; a1 = 0;
    if (fire) begin
      a0 = q.pop_front();
      if (q.size() > 0) begin a1 = q.pop_front(); e1 = 1; end
    end
    chk(mem_en_o == {e1, fire}, tag, "lane enables", mem_en_o, {e1, fire});
    if (fire) begin
      chk(mem_addr_o[18:0] == 19'(a0), tag, "lane0 addr", mem_addr_o[18:0], a0);
      chk(mem_we_o == !m_dir, "R3", "write enable", mem_we_o, !m_dir);
      if (!m_dir) chk(mem_wdata_o == wd, "R3", "write data", mem_wdata_o, wd);
    end
    if (e1) chk(mem_addr_o[37:19] == 19'(a1), tag, "lane1 addr", mem_addr_o[37:19], a1);
    m_done = fire && !m_dir && q.size() == 0;
    m_rvld = fire && m_dir;
    m_rdata = {(e1 ? refget(a1) : 16'h0), (fire ? refget(a0) : 16'h0)};
    if (fire && !m_dir) begin
      refm[a0] = wd[15:0];
      if (e1) refm[a1] = wd[31:16];
    end
    if (fire && q.size() == 0) begin m_busy = 0; m_img = 0; end
    if (st) begin
      mx = int'(pos & 32'h3FF);
      my = int'((pos >> 16) & 32'h1FF);
      mw = int'(((size - 1) & 32'h3FF) + 1);
      mh = int'((((size >> 16) - 1) & 32'h1FF) + 1);
      q.delete();
      for (int r = 0; r < mh; r++)
        for (int c = 0; c < mw; c++)
          q.push_back(((my + r) % 512) * 1024 + ((mx + c) % 1024));
      m_busy = 1; m_dir = sdir; m_img = sdir;
    end
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic words(input int n, input bit rd, input string tag);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, !rd, rd, tag);
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 0; start_i = 0; start_rd_i = 0; pos_i = 0; size_i = 0;
    wr_valid_i = 0; wr_data_i = 0; rd_req_i = 0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(busy_o == 0 && img_ready_o == 0 && done_o == 0, "R10", "status in reset",
        {busy_o, img_ready_o, done_o}, 0);
    chk(rd_valid_o == 0 && mem_en_o == 0, "R10", "ports in reset", {rd_valid_o, mem_en_o}, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(busy_o == 0 && mem_en_o == 0, "R10", "after release", {busy_o, mem_en_o}, 0);

    // R1: stray bits in position and size, 3x2 at (5,7), with a pause mid-row (R5)
    cyc(1, 0, 32'hFE07_FC05, 32'hFE02_FC03, 1, 0, "R1");
    words(1, 0, "R1");
    idle(3, "R5");
    words(2, 0, "R1");
    idle(2, "R8");

    // R3: width 1, words straddle rows
    cyc(1, 0, 32'h0003_0040, 32'h0003_0001, 0, 0, "R3");
    words(2, 0, "R3");
    idle(1, "R8");

    // R4: column and row wrap from (1022,510), 4x4
    cyc(1, 0, 32'h01FE_03FE, 32'h0004_0004, 0, 0, "R4");
    words(3, 0, "R4");
    idle(2, "R5");
    words(5, 0, "R4");
    idle(1, "R8");

    // R2: zero width field gives 1024 columns
    cyc(1, 0, 32'h0064_0000, 32'h0001_0000, 0, 0, "R2");
    words(512, 0, "R2");
    idle(1, "R8");
    // R2: zero height field gives 512 rows
    cyc(1, 0, 32'h0000_000A, 32'h0000_0002, 0, 0, "R2");
    words(512, 0, "R2");
    idle(1, "R8");

    // R7: read back the first rectangle, with gaps
    cyc(1, 1, 32'h0007_0005, 32'h0002_0003, 0, 0, "R7");
    words(1, 1, "R7");
    idle(2, "R5");
    words(2, 1, "R7");
    idle(2, "R6");
    // R7: odd-length read over wrapped and unwritten area
    cyc(1, 1, 32'h01FF_03FF, 32'h0001_0003, 0, 0, "R7");
    words(2, 1, "R7");
    idle(2, "R6");

    // R9: restart replaces a pending write; a word in the start cycle is ignored
    cyc(1, 0, 32'h012C_00C8, 32'h0002_0004, 0, 0, "R9");
    words(1, 0, "R9");
    cyc(1, 0, 32'h003C_0032, 32'h0001_0002, 1, 0, "R9");
    words(1, 0, "R9");
    idle(2, "R8");
    // R6: a write start replaces a pending read
    cyc(1, 1, 32'h0010_0010, 32'h0002_0002, 0, 0, "R6");
    words(1, 1, "R6");
    cyc(1, 0, 32'h0020_0020, 32'h0001_0002, 0, 0, "R6");
    words(1, 0, "R6");
    idle(2, "R8");

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule